// File: doc/BRIEF.md
# Dual-bank 7:1 serial lane deserializer

This block turns ten serial lanes back into parallel pixel words. The lanes form two banks of five: lanes 0 to 4 are the even bank and lanes 5 to 9 are the odd bank. The block runs on a bit clock at seven times the pixel rate. It samples the pixel clock in that domain and uses each rising edge of the pixel clock to frame seven-bit lane words. Each group of seven bits goes through a fixed word pipeline. The 70-bit result is launched on a slot of the bit clock that a two-bit adjust code selects, and a regenerated pixel-rate output clock comes with it.

The output clock can carry valid data on its rising edge or on its falling edge. The data can be moved against that clock in whole bit periods. Each bank has an enable, each lane has a disable, and an active-low power-down holds every output low. The analog receivers, the clock multiplier and the colour mapping sit outside this block.

Top module: `dual_bank_deser`

## Requirements
- R1: While `rst` is high, `dout` and `clk_out` are 0 after every clock edge.
- R2: A bit-clock edge that samples `pix_clk_in` high, after sampling it low on the previous edge, is framing slot 0. The lane bit sampled on slot s (0..6) lands in `dout[7*l + s]` for lane l, so the even bank fills bits 0..34 and the odd bank fills bits 35..69.
- R3: With adjust code 00, the word whose slot-0 bit is sampled on edge E appears on `dout` after edge E+28, which is four pixel periods later, and it is held for seven edges.
- R4: Adjust code 01 moves the word one bit period earlier (after edge E+27). Code 10 moves it one bit period later (after E+29). Code 11 moves it two bit periods earlier (after E+26).
- R5: After an edge in framing slot s, `clk_out` is 1 for s in 3..6 when `strobe_rise` is 1, and it is the inverse of that when `strobe_rise` is 0. The default data change therefore sits three bit periods before the selected strobe edge.
- R6: After any edge where `even_en` is 0, `dout[34:0]` is 0. After any edge where `odd_en` is 0, `dout[69:35]` is 0.
- R7: After any edge where `lane_dis[l]` is 1, the seven bits of lane l on `dout` are 0.
- R8: After any edge where `pwdn_n` is 0, `dout` and `clk_out` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, seven times the pixel rate |
| rst | input | 1 | Synchronous active-high reset |
| pix_clk_in | input | 1 | Pixel clock, sampled in the bit-clock domain for framing |
| ser_in | input | 10 | One serial bit per lane per bit-clock edge |
| pwdn_n | input | 1 | Active-low power-down |
| strobe_rise | input | 1 | 1: data valid on rising edge of clk_out; 0: on falling edge |
| adj | input | 2 | Launch adjust: 00 centred, 01 one early, 10 one late, 11 two early |
| even_en | input | 1 | Even bank enable (lanes 0..4) |
| odd_en | input | 1 | Odd bank enable (lanes 5..9) |
| lane_dis | input | 10 | Per-lane disable, 1 forces the lane low |
| dout | output | 70 | Parallel output word, lane l in bits 7l+6..7l |
| clk_out | output | 1 | Regenerated pixel-rate output clock |

## Verification
The gating assertions assume that the enables, disables and power-down are plain level controls and may change on any cycle. They also assume that the pixel clock is a steady waveform, seven bit periods long, high for four of them, so that every rising edge starts a full frame. The stimulus drives the pixel clock from one free-running cycle counter, so a rising edge falls on every seventh edge from the first edge after reset. Lane data is a pattern that depends only on the word number and the lane. Each control setting is held for six pixel periods before any output is compared, so a change of adjust code or power-down never leaves a partly launched word inside a compared window.

// File: rtl/deser_pkg.sv
package deser_pkg;
  typedef enum logic [1:0] {
    LAUNCH_CENTRE = 2'b00,
    LAUNCH_EARLY1 = 2'b01,
    LAUNCH_LATE1  = 2'b10,
    LAUNCH_EARLY2 = 2'b11
  } launch_e;
endpackage

// File: rtl/deser_framer.sv
module deser_framer #(
  parameter int BITS = 7,
  localparam int CW = $clog2(BITS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pix_clk_in,
  output logic [CW-1:0] slot,
  output logic          word_start
);
  logic          pix_d;
  logic [CW-1:0] cnt_q;
  logic          pix_rise;

  assign pix_rise   = pix_clk_in & ~pix_d;
  assign slot       = pix_rise ? '0 : cnt_q;
  assign word_start = (slot == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_d <= 1'b0;
      cnt_q <= '0;
    end else begin
      pix_d <= pix_clk_in;
      if (slot == CW'(BITS - 1)) cnt_q <= '0;
      else                       cnt_q <= slot + 1'b1;
    end
  end
endmodule

// File: rtl/deser_lanes.sv
module deser_lanes #(
  parameter int BITS = 7,
  parameter int LANES = 10,
  localparam int CW = $clog2(BITS),
  localparam int W = BITS * LANES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] ser_in,
  input  logic [CW-1:0]    slot,
  output logic [W-1:0]     frame
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [BITS-1:0] acc_q;
    always_ff @(posedge clk) begin
      if (rst) acc_q <= '0;
      else     acc_q[slot] <= ser_in[l];
    end
    assign frame[l*BITS +: BITS] = acc_q;
  end
endmodule

// File: rtl/deser_word_pipe.sv
module deser_word_pipe #(
  parameter int W = 70,
  parameter int DEPTH = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         advance,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    logic [W-1:0] src;
    if (s == 0) begin : g_first
      assign src = din;
    end else begin : g_next
      assign src = stage_q[s-1];
    end
    always_ff @(posedge clk) begin
      if (rst)          stage_q[s] <= '0;
      else if (advance) stage_q[s] <= src;
    end
  end

  assign dout = stage_q[DEPTH-1];
endmodule

// File: rtl/deser_launch.sv
module deser_launch
  import deser_pkg::*;
#(
  parameter int BITS = 7,
  parameter int LANES_PER_BANK = 5,
  parameter int BANKS = 2,
  localparam int CW = $clog2(BITS),
  localparam int LANES = LANES_PER_BANK * BANKS,
  localparam int W = BITS * LANES,
  localparam int HI_START = BITS / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CW-1:0]    slot,
  input  logic [W-1:0]     word,
  input  logic [1:0]       adj,
  input  logic             strobe_rise,
  input  logic             pwdn_n,
  input  logic [BANKS-1:0] bank_en,
  input  logic [LANES-1:0] lane_dis,
  output logic [W-1:0]     dout,
  output logic             clk_out
);
  logic [CW-1:0] load_slot;
  logic          load;
  logic [W-1:0]  held_q;
  logic [W-1:0]  mask;
  launch_e       mode;

  assign mode = launch_e'(adj);

  // Held register loads one edge before the output register shows the word.
  always_comb begin
    unique case (mode)
      LAUNCH_CENTRE: load_slot = CW'(BITS - 1);
      LAUNCH_EARLY1: load_slot = CW'(BITS - 2);
      LAUNCH_LATE1:  load_slot = '0;
      default:       load_slot = CW'(BITS - 3);
    endcase
  end
  assign load = (slot == load_slot);

  for (genvar l = 0; l < LANES; l++) begin : g_mask
    assign mask[l*BITS +: BITS] =
      {BITS{bank_en[l / LANES_PER_BANK] & ~lane_dis[l]}};
  end

  always_ff @(posedge clk) begin
    if (rst || !pwdn_n) begin
      held_q  <= '0;
      dout    <= '0;
      clk_out <= 1'b0;
    end else begin
      if (load) held_q <= word;
      dout    <= held_q & mask;
      clk_out <= (slot >= CW'(HI_START)) ^ ~strobe_rise;
    end
  end
endmodule

// File: rtl/dual_bank_deser.sv
module dual_bank_deser #(
  parameter int BITS = 7,
  parameter int LANES_PER_BANK = 5,
  parameter int PIPE_WORDS = 3,
  localparam int BANKS = 2,
  localparam int LANES = LANES_PER_BANK * BANKS,
  localparam int W = BITS * LANES,
  localparam int CW = $clog2(BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pix_clk_in,
  input  logic [LANES-1:0] ser_in,
  input  logic             pwdn_n,
  input  logic             strobe_rise,
  input  logic [1:0]       adj,
  input  logic             even_en,
  input  logic             odd_en,
  input  logic [LANES-1:0] lane_dis,
  output logic [W-1:0]     dout,
  output logic             clk_out
);
  logic [CW-1:0] slot;
  logic          word_start;
  logic [W-1:0]  frame;
  logic [W-1:0]  piped;

  deser_framer #(.BITS(BITS)) u_framer (
    .clk        (clk),
    .rst        (rst),
    .pix_clk_in (pix_clk_in),
    .slot       (slot),
    .word_start (word_start)
  );

  deser_lanes #(.BITS(BITS), .LANES(LANES)) u_lanes (
    .clk    (clk),
    .rst    (rst),
    .ser_in (ser_in),
    .slot   (slot),
    .frame  (frame)
  );

  deser_word_pipe #(.W(W), .DEPTH(PIPE_WORDS)) u_pipe (
    .clk     (clk),
    .rst     (rst),
    .advance (word_start),
    .din     (frame),
    .dout    (piped)
  );

  deser_launch #(
    .BITS(BITS), .LANES_PER_BANK(LANES_PER_BANK), .BANKS(BANKS)
  ) u_launch (
    .clk         (clk),
    .rst         (rst),
    .slot        (slot),
    .word        (piped),
    .adj         (adj),
    .strobe_rise (strobe_rise),
    .pwdn_n      (pwdn_n),
    .bank_en     ({odd_en, even_en}),
    .lane_dis    (lane_dis),
    .dout        (dout),
    .clk_out     (clk_out)
  );
endmodule

// File: rtl/dual_bank_deser_chk.sv
module dual_bank_deser_chk #(
  parameter int BITS = 7,
  parameter int LANES_PER_BANK = 5,
  localparam int LANES = 2 * LANES_PER_BANK,
  localparam int W = BITS * LANES,
  localparam int HALF = BITS * LANES_PER_BANK
) (
  input logic             clk,
  input logic             rst,
  input logic             pwdn_n,
  input logic             even_en,
  input logic             odd_en,
  input logic [LANES-1:0] lane_dis,
  input logic [W-1:0]     dout,
  input logic             clk_out
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (dout == '0 && !clk_out));

  a_r8_powerdown_low: assert property (@(posedge clk) disable iff (rst)
    !pwdn_n |=> (dout == '0 && !clk_out));

  a_r6_even_bank_off: assert property (@(posedge clk) disable iff (rst)
    !even_en |=> (dout[HALF-1:0] == '0));

  a_r6_odd_bank_off: assert property (@(posedge clk) disable iff (rst)
    !odd_en |=> (dout[W-1:HALF] == '0));

  for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
    a_r7_lane_off: assert property (@(posedge clk) disable iff (rst)
      lane_dis[l] |=> (dout[l*BITS +: BITS] == '0));
  end
endmodule

bind dual_bank_deser dual_bank_deser_chk #(
  .BITS(BITS), .LANES_PER_BANK(LANES_PER_BANK)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .pwdn_n   (pwdn_n),
  .even_en  (even_en),
  .odd_en   (odd_en),
  .lane_dis (lane_dis),
  .dout     (dout),
  .clk_out  (clk_out)
);

// File: tb/sim_dual_bank_deser.sv
module sim_dual_bank_deser;
  localparam int CLK_PERIOD = 10;
  localparam int BITS = 7;
  localparam int LANES = 10;
  localparam int W = BITS * LANES;
  localparam int NVEC = 10;
  localparam int SETTLE = 42;
  localparam int WINDOW = 28;

  // {adj, strobe_rise, even_en, odd_en, lane_dis, pwdn_n}
  localparam logic [15:0] VECS [NVEC] = '{
    {2'b00, 1'b1, 1'b1, 1'b1, 10'b0000000000, 1'b1}, // R2 R3 centred
    {2'b01, 1'b1, 1'b1, 1'b1, 10'b0000000000, 1'b1}, // R4 one early
    {2'b10, 1'b1, 1'b1, 1'b1, 10'b0000000000, 1'b1}, // R4 one late
    {2'b11, 1'b1, 1'b1, 1'b1, 10'b0000000000, 1'b1}, // R4 two early
    {2'b00, 1'b0, 1'b1, 1'b1, 10'b0000000000, 1'b1}, // R5 falling strobe
    {2'b00, 1'b1, 1'b0, 1'b1, 10'b0000000000, 1'b1}, // R6 even bank off
    {2'b10, 1'b1, 1'b1, 1'b0, 10'b0000000000, 1'b1}, // R6 odd bank off
    {2'b00, 1'b1, 1'b1, 1'b1, 10'b1000100101, 1'b1}, // R7 lanes off
    {2'b01, 1'b1, 1'b1, 1'b1, 10'b0000000000, 1'b0}, // R8 power-down
    {2'b11, 1'b0, 1'b1, 1'b0, 10'b0000010000, 1'b1}  // R7 R6 mixed
  };
  localparam int VEC_REQ [NVEC] = '{3, 4, 4, 4, 5, 6, 6, 7, 8, 7};

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             pix_clk_in = 1'b0;
  logic [LANES-1:0] ser_in = '0;
  logic             pwdn_n = 1'b1;
  logic             strobe_rise = 1'b1;
  logic [1:0]       adj = 2'b00;
  logic             even_en = 1'b1;
  logic             odd_en = 1'b1;
  logic [LANES-1:0] lane_dis = '0;
  logic [W-1:0]     dout;
  logic             clk_out;

  int  cyc = 0;
  int  n_vec = 0;
  int  n_bad = 0;
  bit  done = 1'b0;

  dual_bank_deser u0 (
    .clk(clk), .rst(rst), .pix_clk_in(pix_clk_in), .ser_in(ser_in),
    .pwdn_n(pwdn_n), .strobe_rise(strobe_rise), .adj(adj),
    .even_en(even_en), .odd_en(odd_en), .lane_dis(lane_dis),
    .dout(dout), .clk_out(clk_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  function automatic logic [BITS-1:0] pat(int w, int l);
    int v;
    v = w * 37 + l * 11 + 5;
    return BITS'(v ^ (w >> 2) ^ (l << 3));
  endfunction

  // Drive the pixel clock and lane bits for the upcoming edge number cyc.
  always @(negedge clk) begin
    pix_clk_in <= (cyc % BITS) < 4;
    for (int l = 0; l < LANES; l++)
      ser_in[l] <= pat(cyc / BITS, l)[cyc % BITS];
  end

  function automatic int offset_of(logic [1:0] a);
    case (a)
      2'b01:   return -1;
      2'b10:   return 1;
      2'b11:   return -2;
      default: return 0;
    endcase
  endfunction

  task automatic check(input int req, input logic [W-1:0] exp_d,
                       input logic exp_c);
    n_vec++;
    if (dout !== exp_d || clk_out !== exp_c) begin
      n_bad++;
      $display("FAIL R%0d edge %0d: dout=%h clk_out=%b expected dout=%h clk_out=%b",
               req, cyc - 1, dout, clk_out, exp_d, exp_c);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    logic [W-1:0] exp_d;
    logic exp_c;
    int m, w;
    // R1: outputs low while reset is held
    repeat (4) @(negedge clk);
    check(1, '0, 1'b0);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      v = VECS[i];
      @(negedge clk);
      adj = v[15:14]; strobe_rise = v[13]; even_en = v[12];
      odd_en = v[11]; lane_dis = v[10:1]; pwdn_n = v[0];
      repeat (SETTLE) @(negedge clk);
      for (int k = 0; k < WINDOW; k++) begin
        @(negedge clk);
        m = cyc - 1;
        w = (m - 4 * BITS - offset_of(adj)) / BITS;
        for (int l = 0; l < LANES; l++) begin
          if (pwdn_n && !lane_dis[l] && ((l < 5) ? even_en : odd_en))
            exp_d[l*BITS +: BITS] = pat(w, l);
          else
            exp_d[l*BITS +: BITS] = '0;
        end
        exp_c = pwdn_n & (((m % BITS) >= 3) ^ ~strobe_rise);
        check(VEC_REQ[i], exp_d, exp_c);
      end
    end

    // R1: reset in the middle of traffic clears the outputs
    @(negedge clk);
    adj = 2'b00; strobe_rise = 1'b0; even_en = 1'b1; odd_en = 1'b1;
    lane_dis = '0; pwdn_n = 1'b1;
    repeat (SETTLE) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(1, '0, 1'b0);
    @(negedge clk);
    check(1, '0, 1'b0);
    finish_run();
  end
endmodule